// File: doc/BRIEF.md
# Cascadable I/Q Serial Output Port

This block sends one frame per output sample over a single serial data wire. A frame is an in-phase word followed directly by a quadrature word, each sent most significant bit first, one bit per serial clock. The port drives the wire only while its own frame is on it. The rest of the time the output is high-impedance and the output enable is low, so several ports can share the wire.

A mode input selects the role. As a bus master, the port starts a frame by itself when a new I/Q pair has been loaded. It announces the frame with a one-clock frame-start pulse. As a cascade slave, the port waits for its frame-start input, which is wired to the frame-end output of the port before it in the chain. Frame-end is raised during the last bit of the quadrature word, so the next port's first bit follows on the next clock with no idle cycle. All ports and the receiving processor share one serial clock.

The frame controller has four states. IDLE waits for work. ARMED is the master's announce cycle. SHIFT_I sends the in-phase word and SHIFT_Q sends the quadrature word. The transitions are:
- IDLE to ARMED: master mode with a pair pending.
- IDLE to SHIFT_I: slave mode with frame-start seen.
- ARMED to SHIFT_I: always, after one cycle.
- SHIFT_I to SHIFT_Q: on the last bit of the in-phase word.
- SHIFT_Q to IDLE: on the last bit of the quadrature word.

Pairs loaded while a frame is in flight wait in a one-entry holding register. Two sticky flags report lost data and repeated data.

Top module: `iq_serial_port`

## Requirements
- R1: After reset, sd_oe, fe_out, fs_out, overrun and stale are all 0.
- R2: A frame occupies 2*W consecutive clocks: bit k of the frame (k = 0 first) is bit W-1-k of the I word for k < W and bit 2W-1-k of the Q word otherwise, with sd_oe = 1 on each of those clocks.
- R3: sd_oe is 0 (and sd_out high-impedance) on every clock on which the port is not sending a frame bit.
- R4: In slave mode (mode_master = 0), a frame-start pulse sampled in IDLE puts the first frame bit on the next clock. Without frame-start, no frame is sent even when a pair is pending.
- R5: fe_out is high for exactly one clock, the clock carrying the last Q bit.
- R6: In master mode (mode_master = 1), a pending pair in IDLE gives one clock of fs_out = 1 with sd_oe = 0, and the first bit follows on the next clock. fs_in has no effect in master mode.
- R7: A frame-start pulse arriving while a frame is being sent neither restarts nor extends that frame.
- R8: A pair loaded while a frame is being sent is held and becomes the next frame. In master mode that frame starts two clocks after the previous frame's last bit.
- R9: A second load before the held pair is sent replaces it, and sets overrun, which stays 1 until reset.
- R10: In slave mode, a frame-start with no new pair since the last frame resends the last pair and sets stale, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_master | input | 1 | 1 = bus master, 0 = cascade slave |
| ld_valid | input | 1 | Load strobe for a new I/Q pair |
| ld_i | input | W | In-phase word to load |
| ld_q | input | W | Quadrature word to load |
| fs_in | input | 1 | Frame-start input (slave mode) |
| fs_out | output | 1 | Frame-start pulse driven by a master |
| fe_out | output | 1 | Frame-end pulse on the last bit |
| sd_out | output | 1 | Serial data, high-impedance when idle |
| sd_oe | output | 1 | Serial data output enable |
| overrun | output | 1 | Sticky: a held pair was overwritten |
| stale | output | 1 | Sticky: a frame repeated old data |

## Verification
A wrong bit counter or state shows on the same frame as a frame longer or shorter than 2*W clocks. It also moves the fe_out pulse or leaves sd_oe high after that pulse. A wrong holding-register flag shows one frame later: either a missing master frame, or the wrong pair sent after a load made during shifting. The sticky flags are read at the end of the scenario that should have set them, and again at the end of the run to confirm they held.

// File: rtl/iqsp_pkg.sv
package iqsp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_SHIFT_I = 2'd2,
        ST_SHIFT_Q = 2'd3
    } iqsp_state_e;

endpackage

// File: rtl/iqsp_pair_buffer.sv
module iqsp_pair_buffer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_valid,
    input  logic [W-1:0] ld_i,
    input  logic [W-1:0] ld_q,
    input  logic         take,
    output logic [W-1:0] pair_i,
    output logic [W-1:0] pair_q,
    output logic         pending,
    output logic         overrun
);

    logic pending_nxt;
    logic overrun_nxt;

    // A load always wins over a take on the same edge: the old pair is
    // consumed and the new one becomes pending.
    always_comb begin
        pending_nxt = pending;
        overrun_nxt = overrun;
        if (ld_valid) begin
            pending_nxt = 1'b1;
            if (pending && !take) begin
                overrun_nxt = 1'b1;
            end
        end else if (take) begin
            pending_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_i  <= '0;
            pair_q  <= '0;
            pending <= 1'b0;
            overrun <= 1'b0;
        end else begin
            pending <= pending_nxt;
            overrun <= overrun_nxt;
            if (ld_valid) begin
                pair_i <= ld_i;
                pair_q <= ld_q;
            end
        end
    end

endmodule

// File: rtl/iqsp_shifter.sv
module iqsp_shifter #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           shift_en,
    input  logic [2*W-1:0] din,
    output logic           bit_out,
    output logic           word_last
);

    localparam int FW = 2 * W;
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [FW-1:0] sreg;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (load) begin
            sreg <= din;
            cnt  <= '0;
        end else if (shift_en) begin
            sreg <= {sreg[FW-2:0], 1'b0};
            cnt  <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_out   = sreg[FW-1];
    assign word_last = (cnt == LAST_IDX);

endmodule

// File: rtl/iqsp_frame_fsm.sv
module iqsp_frame_fsm
    import iqsp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_master,
    input  logic        fs_in,
    input  logic        pending,
    input  logic        word_last,
    output iqsp_state_e state,
    output logic        start,
    output logic        take,
    output logic        shifting,
    output logic        fs_out,
    output logic        fe_out,
    output logic        stale
);

    iqsp_state_e state_nxt;
    logic        slave_start;

    assign slave_start = (state == ST_IDLE) && !mode_master && fs_in;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (mode_master && pending) begin
                    state_nxt = ST_ARMED;
                end else if (slave_start) begin
                    state_nxt = ST_SHIFT_I;
                end
            end
            ST_ARMED:   state_nxt = ST_SHIFT_I;
            ST_SHIFT_I: if (word_last) state_nxt = ST_SHIFT_Q;
            ST_SHIFT_Q: if (word_last) state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // state register and sticky stale flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            stale <= 1'b0;
        end else begin
            state <= state_nxt;
            if (start && !pending) begin
                stale <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        start    = 1'b0;
        shifting = 1'b0;
        fs_out   = 1'b0;
        fe_out   = 1'b0;
        unique case (state)
            ST_IDLE:    start = slave_start;
            ST_ARMED: begin
                start  = 1'b1;
                fs_out = 1'b1;
            end
            ST_SHIFT_I: shifting = 1'b1;
            ST_SHIFT_Q: begin
                shifting = 1'b1;
                fe_out   = word_last;
            end
            default: ;
        endcase
        take = start && pending;
    end

endmodule

// File: rtl/iq_serial_port.sv
module iq_serial_port
    import iqsp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_master,
    input  logic         ld_valid,
    input  logic [W-1:0] ld_i,
    input  logic [W-1:0] ld_q,
    input  logic         fs_in,
    output logic         fs_out,
    output logic         fe_out,
    output logic         sd_out,
    output logic         sd_oe,
    output logic         overrun,
    output logic         stale
);

    logic [W-1:0] pair_i;
    logic [W-1:0] pair_q;
    logic         pending;
    logic         take;
    logic         start;
    logic         shifting;
    logic         word_last;
    logic         bit_out;
    iqsp_state_e  state;

    iqsp_pair_buffer #(.W(W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_i     (ld_i),
        .ld_q     (ld_q),
        .take     (take),
        .pair_i   (pair_i),
        .pair_q   (pair_q),
        .pending  (pending),
        .overrun  (overrun)
    );

    iqsp_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_master (mode_master),
        .fs_in       (fs_in),
        .pending     (pending),
        .word_last   (word_last),
        .state       (state),
        .start       (start),
        .take        (take),
        .shifting    (shifting),
        .fs_out      (fs_out),
        .fe_out      (fe_out),
        .stale       (stale)
    );

    iqsp_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .shift_en  (shifting),
        .din       ({pair_i, pair_q}),
        .bit_out   (bit_out),
        .word_last (word_last)
    );

    assign sd_oe  = shifting;
    assign sd_out = shifting ? bit_out : 1'bz;

endmodule

// File: rtl/iqsp_checker.sv
module iqsp_checker (
    input logic clk,
    input logic rst_n,
    input logic mode_master,
    input logic fs_in,
    input logic fs_out,
    input logic fe_out,
    input logic sd_oe,
    input logic overrun,
    input logic stale
);

    a_r5_fe_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fe_out |=> !fe_out);

    a_r5_fe_during_data: assert property (@(posedge clk) disable iff (!rst_n)
        fe_out |-> sd_oe);

    a_r3_release_after_fe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_oe) |-> $past(fe_out));

    a_r6_fs_precedes_data: assert property (@(posedge clk) disable iff (!rst_n)
        fs_out |-> !sd_oe ##1 sd_oe);

    a_r6_no_fs_as_slave: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_master |-> !fs_out);

    a_r4_slave_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && $rose(sd_oe)) |-> $past(fs_in));

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    a_r10_stale_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stale |=> stale);

endmodule

bind iq_serial_port iqsp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_master (mode_master),
    .fs_in       (fs_in),
    .fs_out      (fs_out),
    .fe_out      (fe_out),
    .sd_oe       (sd_oe),
    .overrun     (overrun),
    .stale       (stale)
);

// File: tb/iq_serial_port_tb_top.sv
module iq_serial_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int FW = 2 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_master = 1'b1;
    logic         ld_valid = 1'b0;
    logic [W-1:0] ld_i = '0;
    logic [W-1:0] ld_q = '0;
    logic         fs_in = 1'b0;
    logic         fs_out, fe_out, sd_out, sd_oe, overrun, stale;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_serial_port #(.W(W)) dut_i (
        .clk (clk), .rst_n (rst_n), .mode_master (mode_master),
        .ld_valid (ld_valid), .ld_i (ld_i), .ld_q (ld_q),
        .fs_in (fs_in), .fs_out (fs_out), .fe_out (fe_out),
        .sd_out (sd_out), .sd_oe (sd_oe),
        .overrun (overrun), .stale (stale)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Put a pair on the load interface for one clock.
    task automatic load_pair(input logic [FW-1:0] p);
        @(negedge clk);
        ld_valid = 1'b1;
        {ld_i, ld_q} = p;
        fs_in = 1'b0;
    endtask

    // n clocks with no frame bit and no frame-start pulse.
    task automatic expect_idle(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(sd_oe == 1'b0, req, "sd_oe idle", int'(sd_oe), 0);
            chk(fs_out == 1'b0, req, "fs_out idle", int'(fs_out), 0);
            ld_valid = 1'b0;
            fs_in    = 1'b0;
        end
    endtask

    // Master announce: one quiet clock, then one clock of fs_out.
    task automatic master_lead();
        @(negedge clk);
        chk(sd_oe == 1'b0 && fs_out == 1'b0, "R6", "pre-announce",
            int'({fs_out, sd_oe}), 0);
        ld_valid = 1'b0;
        fs_in    = 1'b0;
        @(negedge clk);
        chk(fs_out == 1'b1, "R6", "fs_out pulse", int'(fs_out), 1);
        chk(sd_oe == 1'b0, "R6", "no data during announce", int'(sd_oe), 0);
    endtask

    // Check one whole frame, with optional loads or fs pulses during it.
    task automatic check_frame(input logic [FW-1:0] exp, input bit fs_pre,
                               input int ld_at, input logic [FW-1:0] p1,
                               input int ld2_at, input logic [FW-1:0] p2,
                               input int fs_at);
        if (fs_pre) begin
            @(negedge clk);
            fs_in = 1'b1;
            ld_valid = 1'b0;
        end
        for (int k = 0; k < FW; k++) begin
            @(negedge clk);
            chk(sd_oe == 1'b1, "R2", $sformatf("oe bit %0d", k), int'(sd_oe), 1);
            chk(sd_out == exp[FW-1-k], "R2", $sformatf("data bit %0d", k),
                int'(sd_out), int'(exp[FW-1-k]));
            chk(fe_out == (k == FW-1), "R5", $sformatf("fe at bit %0d", k),
                int'(fe_out), int'(k == FW-1));
            fs_in    = (k == fs_at);
            ld_valid = (k == ld_at) || (k == ld2_at);
            if (k == ld_at)  {ld_i, ld_q} = p1;
            if (k == ld2_at) {ld_i, ld_q} = p2;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sd_oe == 0 && fe_out == 0 && fs_out == 0, "R1", "outputs after reset",
            int'({sd_oe, fe_out, fs_out}), 0);
        chk(overrun == 0 && stale == 0, "R1", "flags after reset",
            int'({overrun, stale}), 0);
    endtask

    task automatic t_master_chain();
        mode_master = 1'b1;
        load_pair(32'hA5C3_1E0F);
        master_lead();
        // load B during the frame: held, sent next (R8)
        check_frame(32'hA5C3_1E0F, 1'b0, 7, 32'h8001_7FFE, -1, '0, -1);
        master_lead();
        check_frame(32'h8001_7FFE, 1'b0, -1, '0, -1, '0, -1);
        expect_idle(1, "R3");
        chk(overrun == 1'b0, "R8", "no overrun on single hold", int'(overrun), 0);
    endtask

    task automatic t_overrun();
        load_pair(32'h1234_5678);
        master_lead();
        // two loads during the frame: second replaces first (R9)
        check_frame(32'h1234_5678, 1'b0, 3, 32'hDEAD_BEEF, 20, 32'h0F0F_F0F0, -1);
        master_lead();
        check_frame(32'h0F0F_F0F0, 1'b0, -1, '0, -1, '0, -1);
        expect_idle(3, "R3");
        chk(overrun == 1'b1, "R9", "overrun set", int'(overrun), 1);
    endtask

    task automatic t_slave();
        @(negedge clk);
        mode_master = 1'b0;
        load_pair(32'h6B2D_C491);
        expect_idle(6, "R4");
        // frame-start mid-frame must be ignored (R7)
        check_frame(32'h6B2D_C491, 1'b1, -1, '0, -1, '0, 10);
        expect_idle(4, "R7");
        chk(stale == 1'b0, "R10", "stale clear after fresh frame", int'(stale), 0);
        check_frame(32'h6B2D_C491, 1'b1, -1, '0, -1, '0, -1);
        expect_idle(2, "R3");
        chk(stale == 1'b1, "R10", "stale set on resend", int'(stale), 1);
    endtask

    task automatic t_master_ignores_fs();
        @(negedge clk);
        mode_master = 1'b1;
        fs_in = 1'b1;
        expect_idle(5, "R6");
        chk(overrun == 1'b1 && stale == 1'b1, "R9", "flags still sticky",
            int'({overrun, stale}), 3);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_master_chain();
        t_overrun();
        t_slave();
        t_master_ignores_fs();
        report();
    end

endmodule